// File: doc/BRIEF.md
# SIMT Branch Reconvergence Stack

This block tracks divergent control flow for a single SIMD wavefront. It keeps a small stack of path entries, each holding a program counter, a reconvergence PC and a per-lane execution mask. The top entry always drives the wavefront's current PC, reconvergence PC and active lane mask.

Each cycle the block can accept one branch operation. A conditional branch provides per-lane condition bits and three addresses: the taken target, the fall-through address and the branch's immediate post-dominator. An unconditional branch provides only a target address.

On a conditional branch, the current top entry is retired. In its place, up to three entries are written: a reconvergence entry, a not-taken path and a taken path. The taken path goes on top, so it runs first. An unconditional jump to the current reconvergence PC pops the stack, which rejoins the lanes. Any other jump only moves the top entry's PC.

The post-dominator address is computed elsewhere and arrives as an input.

Top module: `simt_reconv_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stack is cleared to one entry. That entry has the PC from `start_pc`, a reconvergence PC of all ones, and an all-ones lane mask. All three flags clear.
- R2: On a conditional branch, the top entry is retired. If the current reconvergence PC differs from `ipdom_pc`, the top entry is replaced by {pc = `ipdom_pc`, rpc = current rpc, mask = current mask}. If the two are equal, it is dropped with no replacement.
- R3: The taken mask is `cond_bits` AND the current mask. The entry {`target_pc`, `ipdom_pc`, taken mask} is written last, so it becomes the top. It is written only if `target_pc` differs from `ipdom_pc` and the taken mask has at least one lane set.
- R4: The entry {`fallthru_pc`, `ipdom_pc`, current mask AND NOT taken mask} is written before the taken entry. It is written only if `fallthru_pc` differs from `ipdom_pc` and the taken mask's population count is below that of the current mask.
- R5: An unconditional jump whose target equals the current reconvergence PC removes the top entry.
- R6: Any other unconditional jump replaces only the top entry's PC with the target. The entry's reconvergence PC, its mask and the depth stay unchanged.
- R7: A conditional branch whose target equals its fall-through address sets the sticky `path_err_flag` and leaves the stack unchanged.
- R8: A conditional branch with legal addresses leaves a current PC different from the branch's own PC, unless it faulted.
- R9: If an operation would leave more than DEPTH entries, the sticky `overflow_flag` is set and the stack is unchanged. The depth always stays between 1 and DEPTH.
- R10: If an operation would leave zero entries, the sticky `underflow_flag` is set and the stack is unchanged. This covers a pop at depth 1, and a conditional branch at depth 1 that writes no entry.
- R11: `br_kind` is encoded as 0 = idle, 1 = conditional, 2 = unconditional, 3 = reserved. Idle and reserved change nothing.
- R12: The effect of an operation is visible on the outputs after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_pc | input | AW | PC loaded into the base entry at reset |
| br_kind | input | 2 | Operation code (see R11) |
| cond_bits | input | LANES | Per-lane branch condition |
| target_pc | input | AW | Branch target |
| fallthru_pc | input | AW | Address after a not-taken conditional branch |
| ipdom_pc | input | AW | Immediate post-dominator of the conditional branch |
| cur_pc | output | AW | PC of the top entry |
| cur_rpc | output | AW | Reconvergence PC of the top entry |
| cur_mask | output | LANES | Active lanes of the top entry |
| depth | output | $clog2(DEPTH+1) | Number of valid entries |
| overflow_flag | output | 1 | Sticky: a write would have exceeded DEPTH |
| underflow_flag | output | 1 | Sticky: an operation would have emptied the stack |
| path_err_flag | output | 1 | Sticky: conditional branch had target equal to fall-through |

## Verification
A conditional branch can retire the top entry and write new paths in the same cycle. It does this whenever `cur_rpc` already equals `ipdom_pc`.

The bench provokes this in two ways. One is a nested branch inside a diverged path whose post-dominator equals the enclosing reconvergence point. The other is a branch whose lanes are all taken or all not-taken. Both are judged by comparing top PC, rpc, mask and depth against a reference stack model after each operation.

The same overlap also occurs at the capacity boundary. There, a branch that exactly fills DEPTH must succeed, and the next split must raise overflow with no change to the stack.

// File: rtl/reconv_pkg.sv
// Package: shared operation encoding for the reconvergence stack.
// Assumes a two-bit operation code supplied by the issue stage.
package reconv_pkg;
    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_COND = 2'd1,
        BK_JUMP = 2'd2,
        BK_RSVD = 2'd3
    } br_kind_e;

    localparam int SLOT_MAX = 3;
endpackage

// File: rtl/rs_popcnt.sv
// Module: counts set bits of a lane vector.
// Assumes W >= 1; purely combinational.
module rs_popcnt #(
    parameter int W = 64,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits,
    output logic [CW-1:0] count
);
    // Sum each lane bit into the total.
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(bits[i]);
        end
    end
endmodule

// File: rtl/rs_branch_plan.sv
// Module: decides which entries a conditional branch writes and in what order.
// The order is reconvergence, then not-taken, then taken, packed from slot 0.
// Assumes the caller places slot 0 over the retired top entry.
module rs_branch_plan #(
    parameter int LANES = 64,
    parameter int AW    = 32,
    localparam int PCW  = $clog2(LANES + 1)
) (
    input  logic [AW-1:0]             cur_rpc,
    input  logic [LANES-1:0]          cur_mask,
    input  logic [LANES-1:0]          cond_bits,
    input  logic [AW-1:0]             target_pc,
    input  logic [AW-1:0]             fallthru_pc,
    input  logic [AW-1:0]             ipdom_pc,
    output logic [2:0][AW-1:0]        slot_pc,
    output logic [2:0][AW-1:0]        slot_rpc,
    output logic [2:0][LANES-1:0]     slot_mask,
    output logic [1:0]                slot_num
);
    logic [LANES-1:0] taken_mask;
    logic [LANES-1:0] skip_mask;
    logic [1:0][LANES-1:0] cnt_in;
    logic [1:0][PCW-1:0]   cnt_out;
    logic want_reconv, want_skip, want_taken;
    logic [1:0] fill_n;

    // Split the active lanes by condition.
    always_comb begin
        taken_mask = cond_bits & cur_mask;
        skip_mask  = cur_mask & ~taken_mask;
        cnt_in[0]  = taken_mask;
        cnt_in[1]  = cur_mask;
    end

    genvar g;
    for (g = 0; g < 2; g++) begin : g_cnt
        rs_popcnt #(.W(LANES)) u_cnt (
            .bits  (cnt_in[g]),
            .count (cnt_out[g])
        );
    end

    // Evaluate each entry's write condition.
    always_comb begin
        want_reconv = (cur_rpc != ipdom_pc);
        want_skip   = (fallthru_pc != ipdom_pc) && (cnt_out[0] < cnt_out[1]);
        want_taken  = (target_pc != ipdom_pc) && (cnt_out[0] != '0);
    end

    // Pack the selected entries so the taken path lands highest.
    always_comb begin
        fill_n    = 2'd0;
        slot_pc   = '0;
        slot_rpc  = '0;
        slot_mask = '0;
        if (want_reconv) begin
            slot_pc[fill_n]   = ipdom_pc;
            slot_rpc[fill_n]  = cur_rpc;
            slot_mask[fill_n] = cur_mask;
            fill_n = fill_n + 2'd1;
        end
        if (want_skip) begin
            slot_pc[fill_n]   = fallthru_pc;
            slot_rpc[fill_n]  = ipdom_pc;
            slot_mask[fill_n] = skip_mask;
            fill_n = fill_n + 2'd1;
        end
        if (want_taken) begin
            slot_pc[fill_n]   = target_pc;
            slot_rpc[fill_n]  = ipdom_pc;
            slot_mask[fill_n] = taken_mask;
            fill_n = fill_n + 2'd1;
        end
        slot_num = fill_n;
    end
endmodule

// File: rtl/rs_stack_store.sv
// Module: entry storage with a depth counter.
// A load writes up to three entries from a base index and sets a new depth.
// A PC update rewrites only the top entry's PC.
// Assumes the caller has already checked capacity and never asserts both commands at once.
module rs_stack_store #(
    parameter int LANES = 64,
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         start_pc,
    input  logic                  ld_en,
    input  logic [IW-1:0]         ld_base,
    input  logic [1:0]            ld_num,
    input  logic [CW-1:0]         ld_cnt,
    input  logic [2:0][AW-1:0]    ld_pc,
    input  logic [2:0][AW-1:0]    ld_rpc,
    input  logic [2:0][LANES-1:0] ld_mask,
    input  logic                  pc_en,
    input  logic [AW-1:0]         pc_val,
    output logic [AW-1:0]         top_pc,
    output logic [AW-1:0]         top_rpc,
    output logic [LANES-1:0]      top_mask,
    output logic [CW-1:0]         cnt
);
    logic [AW-1:0]    pc_q   [DEPTH];
    logic [AW-1:0]    rpc_q  [DEPTH];
    logic [LANES-1:0] mask_q [DEPTH];
    logic [CW-1:0]    cnt_q;
    logic [IW-1:0]    top_idx;
    logic [IW-1:0]    wr_idx [3];
    logic [2:0]       wr_ok;

    // Locate the top entry.
    always_comb top_idx = IW'(cnt_q - CW'(1));

    // Compute the write slot index and enable for each new entry.
    always_comb begin
        for (int k = 0; k < 3; k++) begin
            wr_idx[k] = IW'(int'(ld_base) + k);
            wr_ok[k]  = ld_en && (k < int'(ld_num)) && ((int'(ld_base) + k) < DEPTH);
        end
    end

    // Reset to the base entry, then apply a load or a PC update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pc_q[i]   <= '0;
                rpc_q[i]  <= '0;
                mask_q[i] <= '0;
            end
            pc_q[0]   <= start_pc;
            rpc_q[0]  <= '1;
            mask_q[0] <= '1;
            cnt_q     <= CW'(1);
        end else if (ld_en) begin
            cnt_q <= ld_cnt;
            for (int k = 0; k < 3; k++) begin
                if (wr_ok[k]) begin
                    pc_q[wr_idx[k]]   <= ld_pc[k];
                    rpc_q[wr_idx[k]]  <= ld_rpc[k];
                    mask_q[wr_idx[k]] <= ld_mask[k];
                end
            end
        end else if (pc_en) begin
            pc_q[top_idx] <= pc_val;
        end
    end

    // Present the top entry.
    always_comb begin
        top_pc   = pc_q[top_idx];
        top_rpc  = rpc_q[top_idx];
        top_mask = mask_q[top_idx];
        cnt      = cnt_q;
    end
endmodule

// File: rtl/simt_reconv_stack.sv
// Module: control-flow stack for one SIMD wavefront.
// Decodes one branch operation per cycle, checks capacity, and commands the store.
// Keeps sticky fault flags.
// Assumes DEPTH >= 2 and that the post-dominator address comes from outside.
module simt_reconv_stack #(
    parameter int LANES = 64,
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    start_pc,
    input  logic [1:0]       br_kind,
    input  logic [LANES-1:0] cond_bits,
    input  logic [AW-1:0]    target_pc,
    input  logic [AW-1:0]    fallthru_pc,
    input  logic [AW-1:0]    ipdom_pc,
    output logic [AW-1:0]    cur_pc,
    output logic [AW-1:0]    cur_rpc,
    output logic [LANES-1:0] cur_mask,
    output logic [CW-1:0]    depth,
    output logic             overflow_flag,
    output logic             underflow_flag,
    output logic             path_err_flag
);
    import reconv_pkg::*;

    br_kind_e               kind;
    logic [2:0][AW-1:0]     slot_pc;
    logic [2:0][AW-1:0]     slot_rpc;
    logic [2:0][LANES-1:0]  slot_mask;
    logic [1:0]             slot_num;
    logic                   ld_en, pc_en;
    logic [1:0]             ld_num;
    logic [CW-1:0]          ld_cnt;
    logic [IW-1:0]          ld_base;
    logic                   set_ovf, set_unf, set_perr;
    int                     need;

    rs_branch_plan #(.LANES(LANES), .AW(AW)) u_plan (
        .cur_rpc     (cur_rpc),
        .cur_mask    (cur_mask),
        .cond_bits   (cond_bits),
        .target_pc   (target_pc),
        .fallthru_pc (fallthru_pc),
        .ipdom_pc    (ipdom_pc),
        .slot_pc     (slot_pc),
        .slot_rpc    (slot_rpc),
        .slot_mask   (slot_mask),
        .slot_num    (slot_num)
    );

    rs_stack_store #(.LANES(LANES), .AW(AW), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_pc (start_pc),
        .ld_en    (ld_en),
        .ld_base  (ld_base),
        .ld_num   (ld_num),
        .ld_cnt   (ld_cnt),
        .ld_pc    (slot_pc),
        .ld_rpc   (slot_rpc),
        .ld_mask  (slot_mask),
        .pc_en    (pc_en),
        .pc_val   (target_pc),
        .top_pc   (cur_pc),
        .top_rpc  (cur_rpc),
        .top_mask (cur_mask),
        .cnt      (depth)
    );

    // Decode the operation and apply the capacity guards.
    always_comb begin
        kind     = br_kind_e'(br_kind);
        ld_en    = 1'b0;
        pc_en    = 1'b0;
        ld_num   = 2'd0;
        ld_cnt   = depth;
        ld_base  = IW'(depth - CW'(1));
        set_ovf  = 1'b0;
        set_unf  = 1'b0;
        set_perr = 1'b0;
        need     = int'(depth) - 1 + int'(slot_num);
        case (kind)
            BK_COND: begin
                if (target_pc == fallthru_pc) begin
                    set_perr = 1'b1;
                end else if (need == 0) begin
                    set_unf = 1'b1;
                end else if (need > DEPTH) begin
                    set_ovf = 1'b1;
                end else begin
                    ld_en  = 1'b1;
                    ld_num = slot_num;
                    ld_cnt = CW'(need);
                end
            end
            BK_JUMP: begin
                if (target_pc == cur_rpc) begin
                    if (depth == CW'(1)) begin
                        set_unf = 1'b1;
                    end else begin
                        ld_en  = 1'b1;
                        ld_cnt = depth - CW'(1);
                    end
                end else begin
                    pc_en = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Hold the sticky fault flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow_flag  <= 1'b0;
            underflow_flag <= 1'b0;
            path_err_flag  <= 1'b0;
        end else begin
            overflow_flag  <= overflow_flag  | set_ovf;
            underflow_flag <= underflow_flag | set_unf;
            path_err_flag  <= path_err_flag  | set_perr;
        end
    end
endmodule

// File: rtl/rs_checker.sv
// Module: protocol checks for the reconvergence stack, bound to the top.
// Assumes a synchronous active-low reset.
module rs_checker #(
    parameter int LANES = 64,
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       br_kind,
    input logic [LANES-1:0] cond_bits,
    input logic [AW-1:0]    target_pc,
    input logic [AW-1:0]    fallthru_pc,
    input logic [AW-1:0]    ipdom_pc,
    input logic [AW-1:0]    cur_pc,
    input logic [AW-1:0]    cur_rpc,
    input logic [LANES-1:0] cur_mask,
    input logic [CW-1:0]    depth,
    input logic             overflow_flag,
    input logic             underflow_flag,
    input logic             path_err_flag
);
    AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (depth >= CW'(1)) && (depth <= CW'(DEPTH))); // R9

    AST_JUMP_RETARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'd2 && target_pc != cur_rpc) |=>
        (cur_pc == $past(target_pc)) && $stable(cur_rpc) && $stable(cur_mask) && $stable(depth)); // R6

    AST_JUMP_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'd2 && target_pc == cur_rpc && depth > CW'(1)) |=>
        (depth == $past(depth) - CW'(1))); // R5

    AST_PATH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'd1 && target_pc == fallthru_pc) |=>
        path_err_flag && $stable(depth) && $stable(cur_pc) && $stable(cur_mask)); // R7

    AST_COND_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'd1 && target_pc != fallthru_pc && target_pc != cur_pc &&
         fallthru_pc != cur_pc && ipdom_pc != cur_pc) |=>
        (cur_pc != $past(cur_pc)) || overflow_flag || underflow_flag); // R8

    AST_TAKEN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'd1 && target_pc != fallthru_pc && target_pc != ipdom_pc &&
         (cond_bits & cur_mask) != '0) |=>
        overflow_flag || ((cur_pc == $past(target_pc)) && (cur_rpc == $past(ipdom_pc)) &&
                          (cur_mask == $past(cond_bits & cur_mask)))); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_flag |=> overflow_flag); // R9

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_flag |=> underflow_flag); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'd0 || br_kind == 2'd3) |=>
        $stable(cur_pc) && $stable(cur_rpc) && $stable(cur_mask) && $stable(depth)); // R11
endmodule

bind simt_reconv_stack rs_checker #(.LANES(LANES), .AW(AW), .DEPTH(DEPTH)) u_rs_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .br_kind        (br_kind),
    .cond_bits      (cond_bits),
    .target_pc      (target_pc),
    .fallthru_pc    (fallthru_pc),
    .ipdom_pc       (ipdom_pc),
    .cur_pc         (cur_pc),
    .cur_rpc        (cur_rpc),
    .cur_mask       (cur_mask),
    .depth          (depth),
    .overflow_flag  (overflow_flag),
    .underflow_flag (underflow_flag),
    .path_err_flag  (path_err_flag)
);

// File: tb/simt_reconv_stack_bench.sv
// Bench: a driver applies operations and queues expected top state from a reference stack model.
// A monitor compares the design one clock edge later.
module simt_reconv_stack_bench;
    localparam int LANES = 64;
    localparam int AW    = 32;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    typedef struct {
        logic [AW-1:0]    pc;
        logic [AW-1:0]    rpc;
        logic [LANES-1:0] mask;
        int               dep;
        bit               ovf;
        bit               unf;
        bit               perr;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    start_pc = 32'h100;
    logic [1:0]       br_kind = 2'd0;
    logic [LANES-1:0] cond_bits = '0;
    logic [AW-1:0]    target_pc = '0;
    logic [AW-1:0]    fallthru_pc = '0;
    logic [AW-1:0]    ipdom_pc = '0;
    logic [AW-1:0]    cur_pc, cur_rpc;
    logic [LANES-1:0] cur_mask;
    logic [CW-1:0]    depth;
    logic             overflow_flag, underflow_flag, path_err_flag;

    exp_t             exp_q[$];
    exp_t             mon_e;
    logic [AW-1:0]    m_pc   [DEPTH];
    logic [AW-1:0]    m_rpc  [DEPTH];
    logic [LANES-1:0] m_mask [DEPTH];
    int               m_cnt;
    bit               m_ovf, m_unf, m_perr;
    int               n_cmp = 0;
    int               n_bad = 0;

    always #5 clk = ~clk;

    simt_reconv_stack #(.LANES(LANES), .AW(AW), .DEPTH(DEPTH)) u_simt_reconv_stack (
        .clk(clk), .rst_n(rst_n), .start_pc(start_pc), .br_kind(br_kind),
        .cond_bits(cond_bits), .target_pc(target_pc), .fallthru_pc(fallthru_pc),
        .ipdom_pc(ipdom_pc), .cur_pc(cur_pc), .cur_rpc(cur_rpc), .cur_mask(cur_mask),
        .depth(depth), .overflow_flag(overflow_flag), .underflow_flag(underflow_flag),
        .path_err_flag(path_err_flag)
    );

    // Compare the outputs against one expected snapshot.
    task automatic compare(input exp_t e);
        n_cmp++;
        if (cur_pc !== e.pc || cur_rpc !== e.rpc || cur_mask !== e.mask ||
            int'(depth) != e.dep || overflow_flag !== e.ovf ||
            underflow_flag !== e.unf || path_err_flag !== e.perr) begin
            n_bad++;
            $display("FAIL %s: actual pc=%h rpc=%h mask=%h depth=%0d flags=%b%b%b expected pc=%h rpc=%h mask=%h depth=%0d flags=%b%b%b",
                     e.tag, cur_pc, cur_rpc, cur_mask, depth, overflow_flag, underflow_flag,
                     path_err_flag, e.pc, e.rpc, e.mask, e.dep, e.ovf, e.unf, e.perr);
        end
    endtask

    // Build the expected snapshot from the model's top entry.
    function automatic exp_t snap(input string tag);
        exp_t e;
        e.pc   = m_pc[m_cnt-1];
        e.rpc  = m_rpc[m_cnt-1];
        e.mask = m_mask[m_cnt-1];
        e.dep  = m_cnt;
        e.ovf  = m_ovf;
        e.unf  = m_unf;
        e.perr = m_perr;
        e.tag  = tag;
        return e;
    endfunction

    // Drive one operation, advance the reference model, queue the result, then go idle.
    task automatic do_op(input logic [1:0] k, input logic [LANES-1:0] cb,
                         input logic [AW-1:0] tg, input logic [AW-1:0] ft,
                         input logic [AW-1:0] ip, input string tag);
        logic [AW-1:0]    c_rpc;
        logic [LANES-1:0] c_mask, tk;
        logic [AW-1:0]    n_pc   [3];
        logic [AW-1:0]    n_rpc  [3];
        logic [LANES-1:0] n_mask [3];
        int n, need;
        @(negedge clk);
        br_kind = k; cond_bits = cb; target_pc = tg; fallthru_pc = ft; ipdom_pc = ip;
        c_rpc  = m_rpc[m_cnt-1];
        c_mask = m_mask[m_cnt-1];
        if (k == 2'd1) begin
            if (tg == ft) begin
                m_perr = 1'b1;
            end else begin
                tk = cb & c_mask;
                n = 0;
                if (c_rpc != ip) begin
                    n_pc[n] = ip; n_rpc[n] = c_rpc; n_mask[n] = c_mask; n++;
                end
                if (ft != ip && $countones(tk) < $countones(c_mask)) begin
                    n_pc[n] = ft; n_rpc[n] = ip; n_mask[n] = c_mask & ~tk; n++;
                end
                if (tg != ip && tk != '0) begin
                    n_pc[n] = tg; n_rpc[n] = ip; n_mask[n] = tk; n++;
                end
                need = m_cnt - 1 + n;
                if (need == 0) m_unf = 1'b1;
                else if (need > DEPTH) m_ovf = 1'b1;
                else begin
                    for (int i = 0; i < n; i++) begin
                        m_pc[m_cnt-1+i] = n_pc[i];
                        m_rpc[m_cnt-1+i] = n_rpc[i];
                        m_mask[m_cnt-1+i] = n_mask[i];
                    end
                    m_cnt = need;
                end
            end
        end else if (k == 2'd2) begin
            if (tg == c_rpc) begin
                if (m_cnt == 1) m_unf = 1'b1;
                else m_cnt--;
            end else begin
                m_pc[m_cnt-1] = tg;
            end
        end
        exp_q.push_back(snap(tag));
        @(negedge clk);
        br_kind = 2'd0;
    endtask

    // Monitor: check each queued result just after the edge that applies it (R12).
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            compare(mon_e);
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        n_bad++;
        $display("FAIL R12 watchdog expired: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_cnt = 1; m_pc[0] = 32'h100; m_rpc[0] = '1; m_mask[0] = '1;
        m_ovf = 0; m_unf = 0; m_perr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(snap("R1 reset state"));

        do_op(2'd2, '0, 32'h200, 32'h0, 32'h0, "R6 jump retarget");
        do_op(2'd1, 64'h0000_0000_FFFF_FFFF, 32'h300, 32'h204, 32'h400, "R2 R3 R4 R8 split");
        do_op(2'd2, '0, 32'h310, 32'h0, 32'h0, "R6 jump within path");
        do_op(2'd2, '0, 32'h400, 32'h0, 32'h0, "R5 pop at rpc");
        do_op(2'd1, '1, 32'h250, 32'h208, 32'h400, "R2 R4 all lanes taken, top retired");
        do_op(2'd1, '0, 32'h260, 32'h254, 32'h400, "R3 no taken lanes");
        do_op(2'd3, '1, 32'h999, 32'h998, 32'h400, "R11 reserved code");
        do_op(2'd0, '1, 32'h400, 32'h404, 32'h400, "R11 idle code");
        do_op(2'd1, '1, 32'h270, 32'h270, 32'h500, "R7 target equals fall-through");
        do_op(2'd2, '0, 32'h400, 32'h0, 32'h0, "R5 pop to base");
        do_op(2'd2, '0, 32'hFFFF_FFFF, 32'h0, 32'h0, "R10 pop at depth 1");
        do_op(2'd1, {16{4'h5}}, 32'h500, 32'h404, 32'h600, "R2 R3 R4 nest 1");
        do_op(2'd1, {16{4'h3}}, 32'h520, 32'h504, 32'h580, "R2 R3 R4 nest 2");
        do_op(2'd1, {8{8'h0F}}, 32'h540, 32'h524, 32'h560, "R3 R4 nest 3");
        do_op(2'd1, '1, 32'h544, 32'h542, 32'h548, "R9 exact fill to DEPTH");
        do_op(2'd1, {4{16'h0001}}, 32'h5C0, 32'h5C4, 32'h54C, "R9 overflow");
        do_op(2'd2, '0, 32'h548, 32'h0, 32'h0, "R5 pop after overflow");
        do_op(2'd1, {4{16'h0001}}, 32'h5A0, 32'h560, 32'h560, "R4 fall-through at post-dominator");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule